// File: doc/BRIEF.md
# Nibble-Wide Page-Mode DRAM Sequencer

This block drives a dynamic RAM whose data pins are four bits wide, so that a requester with an 8-bit data path can read and write whole bytes. It runs from a 16 MHz clock and divides time into fixed slots of eight clocks, which gives a 2 MHz slot rate. In each slot that carries a request, the block opens one row and then makes two column accesses inside that row. The first column access moves the low half-byte and the second moves the high half-byte.

The requester watches `slot_sync`. On the clock edge where `slot_sync` is high, the block samples a request: a valid flag, a read/write level, a 16-bit byte address and the write byte. The next eight clocks form the slot that serves it. During that slot the block drives the row strobe, the column strobe, the multiplexed address and write-enable. On a read it captures the two half-bytes from the RAM and returns them as one byte with a one-clock valid strobe. On a write it drives each half-byte onto the data pins only while the matching column strobe is low. Refresh and arbitration between requesters are handled elsewhere.

Top module: `nibble_dram_seq`

## Requirements
- R1: During reset and after it, `dram_ras_n`, `dram_cas_n` and `dram_we_n` are high and `dram_dq_oe` and `rd_valid` are low until a request is taken. The slot phase starts at 0 after reset. `slot_sync` is high only while the phase is 7, so it is first high on the 7th clock edge after reset release and then once every 8 clocks.
- R2: A request is sampled on the clock edge where `slot_sync` is high. The eight following clocks are phases 0 to 7 of its slot. A slot with no valid request keeps all strobes high and the data pins undriven.
- R3: In a requested slot, `dram_ras_n` is high in phases 0 and 1 (2 clocks, 125 ns) and low in phases 2 to 7 (6 clocks, 375 ns).
- R4: In a requested slot, `dram_cas_n` is low in phases 3–4 and 6–7 and high in all other phases. It is never low while `dram_ras_n` is high, and it stays high for at least one clock between the two column accesses.
- R5: `dram_addr` carries the row, `req_addr[15:8]`, in phases 0 to 2. It carries the first column, `{req_addr[7:1],0}`, in phases 3 and 4, and the second column, `{req_addr[7:1],1}`, in phases 5 to 7.
- R6: `dram_we_n` is low in phases 2 to 7 of a write slot and high for the whole of a read slot. It never changes on the clock where `dram_cas_n` falls.
- R7: On a write, `dram_dq_oe` is high exactly in the phases where `dram_cas_n` is low. `dram_dq_out` equals `req_wdata[3:0]` in phases 3–4 and `req_wdata[7:4]` in phases 6–7.
- R8: On a read, the half-byte on `dram_dq_in` is captured on the last clock of each column-strobe low period, which is the end of phase 4 and the end of phase 7. The first column gives bits [3:0] and the second gives bits [7:4]. `rd_data` presents the byte and `rd_valid` pulses for exactly one clock in phase 0 after the slot. `rd_data` holds until the next read completes.
- R9: Byte address bit 0 selects no storage. Two byte addresses that differ only in bit 0 read and write the same byte.
- R10: A write slot or an empty slot produces no `rd_valid` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 16 MHz system clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | A request is present, sampled when slot_sync is high |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Byte address |
| req_wdata | input | 8 | Byte to write |
| slot_sync | output | 1 | High in the last clock of each slot; a request is taken at its edge |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_addr | output | 8 | Multiplexed row/column address |
| dram_dq_in | input | 4 | Half-byte from the RAM |
| dram_dq_out | output | 4 | Half-byte to the RAM |
| dram_dq_oe | output | 1 | Drive enable for dram_dq_out |
| rd_data | output | 8 | Assembled read byte |
| rd_valid | output | 1 | One-clock strobe marking a new rd_data |

## Verification
Directed slots come first. A write followed by a read of the same address shows whether the half-bytes are placed in the right order, because the test byte has different high and low nibbles. A read of the partner address, which differs only in bit 0, shows the bit-0 aliasing. An empty slot and a write slot show that no strobe or valid pulse appears without a read. After that, random slots mix reads, writes and empty slots over a few rows and a narrow column range, so that reads often hit bytes written earlier. In every phase of every slot, each pin is compared against the schedule the bench computes for that phase, so a strobe edge that is off by one clock or an address field that is in the wrong place is caught.

// File: rtl/nds_pkg.sv
// nds_pkg: shared helpers for the nibble DRAM sequencer.
// Assumes column accesses are laid out back to back with a fixed gap.
package nds_pkg;

    // First phase of column access idx.
    function automatic int col_start(input int idx, input int first,
                                     input int len, input int gap);
        return first + idx * (len + gap);
    endfunction

    // Phase just after column access idx ends (strobe back high).
    function automatic int col_end(input int idx, input int first,
                                   input int len, input int gap);
        return first + idx * (len + gap) + len;
    endfunction

endpackage

// File: rtl/nds_slot_timer.sv
// nds_slot_timer: free-running phase counter that divides the system
// clock into fixed slots. Assumes SLOT_LEN is a power of two.
module nds_slot_timer #(
    parameter int SLOT_LEN = 8,
    localparam int PH_W = $clog2(SLOT_LEN)
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic [PH_W-1:0] phase,
    output logic            slot_last
);
    localparam logic [PH_W-1:0] LAST_PH = PH_W'(SLOT_LEN - 1);

    // Advance the phase every clock and wrap at the end of the slot.
    always_ff @(posedge clk) begin
        if (!rst_n) phase <= '0;
        else if (phase == LAST_PH) phase <= '0;
        else phase <= phase + 1'b1;
    end

    assign slot_last = (phase == LAST_PH);

    AST_PHASE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        slot_last |=> (phase == '0)); // R1
    AST_SYNC_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        slot_last |=> !slot_last); // R1
endmodule

// File: rtl/nds_strobe_gen.sv
// nds_strobe_gen: decodes the slot phase and the held request into the
// row strobe, column strobe, write enable and multiplexed address.
// Assumes the request registers change only at the start of a slot.
module nds_strobe_gen #(
    parameter int ADDR_W    = 16,
    parameter int NIBS      = 2,
    parameter int SLOT_LEN  = 8,
    parameter int RAS_PRE   = 2,
    parameter int CAS_FIRST = 3,
    parameter int CAS_LEN   = 2,
    parameter int CAS_GAP   = 1,
    localparam int PH_W  = $clog2(SLOT_LEN),
    localparam int MA_W  = ADDR_W / 2,
    localparam int SEL_W = $clog2(NIBS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PH_W-1:0]   phase,
    input  logic              active,
    input  logic              lat_we,
    input  logic [ADDR_W-1:0] lat_addr,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [MA_W-1:0]   dram_addr,
    output logic [SEL_W-1:0]  col_idx,
    output logic              cas_low
);
    localparam int RAS_LOW = SLOT_LEN - RAS_PRE;

    logic [NIBS-1:0] col_hit;
    logic            row_phase;
    logic            ras_on;

    // One window detector per column access.
    for (genvar i = 0; i < NIBS; i++) begin : g_col
        localparam int CS = nds_pkg::col_start(i, CAS_FIRST, CAS_LEN, CAS_GAP);
        localparam int CE = nds_pkg::col_end(i, CAS_FIRST, CAS_LEN, CAS_GAP);
        assign col_hit[i] = active && (int'(phase) >= CS) && (int'(phase) < CE);
    end

    // Pick which column address is on the bus: it advances once the
    // previous column strobe has gone back high.
    always_comb begin
        col_idx = '0;
        for (int i = 1; i < NIBS; i++) begin
            if (int'(phase) >= nds_pkg::col_end(i - 1, CAS_FIRST, CAS_LEN, CAS_GAP))
                col_idx = SEL_W'(i);
        end
    end

    // Row address until the first column strobe, column address after.
    always_comb begin
        row_phase = int'(phase) < CAS_FIRST;
        if (row_phase) dram_addr = lat_addr[ADDR_W-1:MA_W];
        else           dram_addr = {lat_addr[MA_W-1:SEL_W], col_idx};
    end

    // Strobe and write-enable levels for the current phase.
    always_comb begin
        ras_on  = active && (int'(phase) >= RAS_PRE);
        ras_n   = !ras_on;
        cas_low = |col_hit;
        cas_n   = !cas_low;
        we_n    = !(ras_on && lat_we);
    end

    // Run-length counters used only by the timing checks below.
    logic [PH_W:0] ras_low_cnt;
    logic [PH_W:0] cas_hi_cnt;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ras_low_cnt <= '0;
            cas_hi_cnt  <= '0;
        end else begin
            ras_low_cnt <= ras_n ? '0 : ras_low_cnt + 1'b1;
            cas_hi_cnt  <= cas_n ? ((&cas_hi_cnt) ? cas_hi_cnt : cas_hi_cnt + 1'b1) : '0;
        end
    end

    AST_RAS_LOW_TIME: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ras_n) |-> (int'(ras_low_cnt) == RAS_LOW)); // R3
    AST_CAS_HIGH_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cas_n) |-> (int'(cas_hi_cnt) >= CAS_GAP)); // R4
    AST_CAS_UNDER_RAS: assert property (@(posedge clk) disable iff (!rst_n)
        !cas_n |-> !ras_n); // R4
    AST_WE_SETTLED: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cas_n) |-> $stable(we_n)); // R6
endmodule

// File: rtl/nds_byte_pack.sv
// nds_byte_pack: splits the write byte into half-bytes for the data pins
// and gathers the read half-bytes into one byte. Assumes NIBS >= 2 and
// that dram_dq_in is stable through the last clock of each strobe low.
module nds_byte_pack #(
    parameter int DATA_W    = 8,
    parameter int NIB_W     = 4,
    parameter int SLOT_LEN  = 8,
    parameter int CAS_FIRST = 3,
    parameter int CAS_LEN   = 2,
    parameter int CAS_GAP   = 1,
    localparam int NIBS  = DATA_W / NIB_W,
    localparam int PH_W  = $clog2(SLOT_LEN),
    localparam int SEL_W = $clog2(NIBS),
    localparam int STG_W = DATA_W - NIB_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PH_W-1:0]   phase,
    input  logic              active,
    input  logic              lat_we,
    input  logic [DATA_W-1:0] lat_wdata,
    input  logic [SEL_W-1:0]  col_idx,
    input  logic              cas_low,
    input  logic [NIB_W-1:0]  dq_in,
    output logic [NIB_W-1:0]  dq_out,
    output logic              dq_oe,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid
);
    localparam int LAST_CAP =
        nds_pkg::col_end(NIBS - 1, CAS_FIRST, CAS_LEN, CAS_GAP) - 1;

    logic [STG_W-1:0] stage;
    logic             reading;
    logic             last_cap;

    assign reading  = active && !lat_we;
    assign last_cap = reading && (int'(phase) == LAST_CAP);

    // Drive the half-byte of the current column only while its strobe is low.
    assign dq_oe  = active && lat_we && cas_low;
    assign dq_out = lat_wdata[col_idx*NIB_W +: NIB_W];

    // Hold every half-byte except the last until the byte is complete.
    for (genvar i = 0; i < NIBS - 1; i++) begin : g_cap
        localparam int CAP_PH =
            nds_pkg::col_end(i, CAS_FIRST, CAS_LEN, CAS_GAP) - 1;
        always_ff @(posedge clk) begin
            if (!rst_n) stage[i*NIB_W +: NIB_W] <= '0;
            else if (reading && int'(phase) == CAP_PH)
                stage[i*NIB_W +: NIB_W] <= dq_in;
        end
    end

    // Assemble the byte with the final half-byte and hold it for the requester.
    always_ff @(posedge clk) begin
        if (!rst_n) rd_data <= '0;
        else if (last_cap) rd_data <= {dq_in, stage};
    end

    // One-clock completion strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) rd_valid <= 1'b0;
        else rd_valid <= last_cap;
    end

    AST_RDV_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid); // R8
    AST_RDATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(last_cap) |-> $stable(rd_data)); // R8
endmodule

// File: rtl/nibble_dram_seq.sv
// nibble_dram_seq: byte-wide front end for a half-byte-wide DRAM. Takes
// one request per slot at slot_sync and serves it with one row open and
// one column access per half-byte. Assumes the requester holds its
// inputs valid on the slot_sync clock; refresh is handled elsewhere.
module nibble_dram_seq #(
    parameter int ADDR_W    = 16,
    parameter int DATA_W    = 8,
    parameter int NIB_W     = 4,
    parameter int SLOT_LEN  = 8,
    parameter int RAS_PRE   = 2,
    parameter int CAS_FIRST = 3,
    parameter int CAS_LEN   = 2,
    parameter int CAS_GAP   = 1,
    localparam int NIBS  = DATA_W / NIB_W,
    localparam int PH_W  = $clog2(SLOT_LEN),
    localparam int MA_W  = ADDR_W / 2,
    localparam int SEL_W = $clog2(NIBS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_we,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              slot_sync,
    output logic              dram_ras_n,
    output logic              dram_cas_n,
    output logic              dram_we_n,
    output logic [MA_W-1:0]   dram_addr,
    input  logic [NIB_W-1:0]  dram_dq_in,
    output logic [NIB_W-1:0]  dram_dq_out,
    output logic              dram_dq_oe,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid
);
    logic [PH_W-1:0]   phase;
    logic              active;
    logic              lat_we;
    logic [ADDR_W-1:0] lat_addr;
    logic [DATA_W-1:0] lat_wdata;
    logic [SEL_W-1:0]  col_idx;
    logic              cas_low;

    nds_slot_timer #(.SLOT_LEN(SLOT_LEN)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .phase     (phase),
        .slot_last (slot_sync)
    );

    // Capture the request at the slot boundary and hold it for the slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active    <= 1'b0;
            lat_we    <= 1'b0;
            lat_addr  <= '0;
            lat_wdata <= '0;
        end else if (slot_sync) begin
            active    <= req_valid;
            lat_we    <= req_we;
            lat_addr  <= req_addr;
            lat_wdata <= req_wdata;
        end
    end

    nds_strobe_gen #(
        .ADDR_W(ADDR_W), .NIBS(NIBS), .SLOT_LEN(SLOT_LEN), .RAS_PRE(RAS_PRE),
        .CAS_FIRST(CAS_FIRST), .CAS_LEN(CAS_LEN), .CAS_GAP(CAS_GAP)
    ) u_strobe (
        .clk       (clk),
        .rst_n     (rst_n),
        .phase     (phase),
        .active    (active),
        .lat_we    (lat_we),
        .lat_addr  (lat_addr),
        .ras_n     (dram_ras_n),
        .cas_n     (dram_cas_n),
        .we_n      (dram_we_n),
        .dram_addr (dram_addr),
        .col_idx   (col_idx),
        .cas_low   (cas_low)
    );

    nds_byte_pack #(
        .DATA_W(DATA_W), .NIB_W(NIB_W), .SLOT_LEN(SLOT_LEN),
        .CAS_FIRST(CAS_FIRST), .CAS_LEN(CAS_LEN), .CAS_GAP(CAS_GAP)
    ) u_pack (
        .clk       (clk),
        .rst_n     (rst_n),
        .phase     (phase),
        .active    (active),
        .lat_we    (lat_we),
        .lat_wdata (lat_wdata),
        .col_idx   (col_idx),
        .cas_low   (cas_low),
        .dq_in     (dram_dq_in),
        .dq_out    (dram_dq_out),
        .dq_oe     (dram_dq_oe),
        .rd_data   (rd_data),
        .rd_valid  (rd_valid)
    );

    AST_OE_IN_WRITE_CAS: assert property (@(posedge clk) disable iff (!rst_n)
        dram_dq_oe |-> (!dram_cas_n && !dram_we_n)); // R7
    AST_NO_RDV_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(dram_we_n)); // R10
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        dram_ras_n |-> (dram_cas_n && dram_we_n && !dram_dq_oe)); // R2
endmodule

// File: tb/tb_nibble_dram_seq.sv
module tb_nibble_dram_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_we = 1'b0;
    logic [15:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        slot_sync;
    logic        dram_ras_n, dram_cas_n, dram_we_n, dram_dq_oe, rd_valid;
    logic [7:0]  dram_addr, rd_data;
    logic [3:0]  dram_dq_in = '0;
    logic [3:0]  dram_dq_out;

    int n_tests = 0;
    int n_fail  = 0;

    always #10 clk = ~clk;

    nibble_dram_seq dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_we(req_we),
        .req_addr(req_addr), .req_wdata(req_wdata), .slot_sync(slot_sync),
        .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n),
        .dram_addr(dram_addr), .dram_dq_in(dram_dq_in), .dram_dq_out(dram_dq_out),
        .dram_dq_oe(dram_dq_oe), .rd_data(rd_data), .rd_valid(rd_valid)
    );

    // Behavioural half-byte DRAM: latches row and column on strobe falls.
    logic [3:0] mem [int unsigned];
    logic [7:0] row_l = '0;
    logic [7:0] col_l = '0;
    logic       prev_ras = 1'b1;
    logic       prev_cas = 1'b1;
    always @(negedge clk) begin
        if (prev_ras && !dram_ras_n) row_l = dram_addr;
        if (prev_cas && !dram_cas_n) begin
            col_l = dram_addr;
            if (!dram_we_n) mem[{16'd0, row_l, col_l}] = dram_dq_out;
            dram_dq_in = mem.exists({16'd0, row_l, col_l}) ? mem[{16'd0, row_l, col_l}] : 4'h0;
        end
        prev_ras = dram_ras_n;
        prev_cas = dram_cas_n;
    end

    // Reference byte store, keyed by the byte address without bit 0 (R9).
    logic [7:0] ref_mem [int unsigned];

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_read(input logic [15:0] a);
        return ref_mem.exists({17'd0, a[15:1]}) ? ref_mem[{17'd0, a[15:1]}] : 8'h00;
    endfunction

    // Run one slot and check every pin in every phase against the schedule.
    task automatic do_slot(input bit v, input bit we, input logic [15:0] a, input logic [7:0] d);
        bit e_ras, e_cas, e_we, e_oe;
        logic [7:0] e_addr;
        while (!slot_sync) @(negedge clk);
        req_valid = v; req_we = we; req_addr = a; req_wdata = d;
        for (int p = 0; p < 8; p++) begin
            @(negedge clk);
            if (p == 0) begin req_valid = 1'b0; req_addr = ~a; req_wdata = ~d; end
            e_ras  = !(v && p >= 2);                                  // R3
            e_cas  = !(v && (p == 3 || p == 4 || p == 6 || p == 7));  // R4
            e_we   = !(v && we && p >= 2);                            // R6
            e_oe   = v && we && !e_cas;                               // R7
            e_addr = (p < 3) ? a[15:8] : {a[7:1], (p >= 5) ? 1'b1 : 1'b0}; // R5
            chk(slot_sync == (p == 7), "R1 slot_sync", int'(slot_sync), int'(p == 7));
            chk(dram_ras_n == e_ras, v ? "R3 ras_n" : "R2 idle ras_n", int'(dram_ras_n), int'(e_ras));
            chk(dram_cas_n == e_cas, v ? "R4 cas_n" : "R2 idle cas_n", int'(dram_cas_n), int'(e_cas));
            chk(dram_we_n == e_we, "R6 we_n", int'(dram_we_n), int'(e_we));
            chk(dram_dq_oe == e_oe, "R7 dq_oe", int'(dram_dq_oe), int'(e_oe));
            if (v) chk(dram_addr == e_addr, "R5 addr", int'(dram_addr), int'(e_addr));
            if (e_oe) chk(dram_dq_out == ((p < 5) ? d[3:0] : d[7:4]), "R7 dq_out",
                          int'(dram_dq_out), int'((p < 5) ? d[3:0] : d[7:4]));
            chk(rd_valid == 1'b0, "R8 rd_valid inside slot", int'(rd_valid), 0);
        end
        if (v && we) ref_mem[{17'd0, a[15:1]}] = d;
        @(negedge clk);
        if (v && !we) begin
            chk(rd_valid == 1'b1, "R8 rd_valid pulse", int'(rd_valid), 1);
            chk(rd_data == exp_read(a), "R8 rd_data", int'(rd_data), int'(exp_read(a)));
        end else begin
            chk(rd_valid == 1'b0, "R10 no rd_valid", int'(rd_valid), 0);
        end
    endtask

    initial begin
        logic [7:0] held;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(dram_ras_n && dram_cas_n && dram_we_n, "R1 strobes in reset",
            int'({dram_ras_n, dram_cas_n, dram_we_n}), 7);
        chk(!dram_dq_oe && !rd_valid, "R1 oe/valid in reset", int'({dram_dq_oe, rd_valid}), 0);
        rst_n = 1'b1;
        for (int i = 1; i <= 7; i++) begin
            @(negedge clk);
            chk(slot_sync == (i == 7), "R1 first slot_sync", int'(slot_sync), int'(i == 7));
        end
        // Directed cases.
        do_slot(1'b0, 1'b0, 16'h0000, 8'h00);                  // R2 empty slot
        do_slot(1'b1, 1'b1, 16'h1234, 8'hA5);                  // R7 write
        do_slot(1'b1, 1'b0, 16'h1234, 8'h00);                  // R8 read back
        held = rd_data;
        do_slot(1'b1, 1'b0, 16'h1235, 8'h00);                  // R9 alias read
        chk(rd_data == 8'hA5, "R9 alias byte", int'(rd_data), 8'hA5);
        do_slot(1'b1, 1'b1, 16'hFFFF, 8'h3C);                  // R9 alias write
        chk(rd_data == held, "R8 rd_data held across write", int'(rd_data), int'(held));
        do_slot(1'b1, 1'b0, 16'hFFFE, 8'h00);                  // R9
        chk(rd_data == 8'h3C, "R9 alias write", int'(rd_data), 8'h3C);
        // Random mix over a few rows and a narrow column range.
        for (int k = 0; k < 60; k++) begin
            int unsigned r = $urandom;
            logic [15:0] a;
            a = {8'h40 + 8'(r % 3), 5'b0, 3'(r >> 4)};
            do_slot(((r >> 8) % 6) != 0, r[12], a, 8'($urandom));
        end
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule